// File: doc/BRIEF.md
# Comb-Filter Stereo Synthesizer

This block turns a mono stream of signed PCM samples into a left/right pair. Each accepted sample is mixed with the sample that arrived a selectable number of samples earlier. The right channel takes the sum of the two and the left channel takes their difference. The two channels therefore behave as complementary comb filters. Tones at whole multiples of 1/delay pass on the right and are notched on the left. Tones at odd multiples of half that frequency do the opposite. Spreading one mono source across the stereo field this way gives it apparent width.

The delay is chosen by a 3-bit code with eight settings, from half a millisecond to four milliseconds in half-millisecond steps. The code is taken in while reset is held, and that setting stays until the next reset. The delay line is a circular buffer in internal memory, sized for the longest setting at the sample rate given as a parameter. Each result is halved before it leaves the block, so neither output can overflow the sample width.

Top module: `comb_stereo`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `left` and `right` are all cleared to zero at that edge.
- R2: `out_valid` is high for exactly one cycle, in the cycle after each clock edge where `in_valid` was high. `left` and `right` keep their values in every cycle that follows an edge without an accepted sample.
- R3: `right` equals (x + d) shifted right one place arithmetically, with the sum formed at DATA_W+1 bits. Here x is the accepted sample and d is its delayed partner, both two's complement. Full-scale inputs never wrap.
- R4: `left` equals (x − d) shifted right one place arithmetically, with the difference formed at DATA_W+1 bits, so full-scale inputs never wrap.
- R5: d is the sample accepted exactly D accepted samples earlier. D = (code + 1) × SAMPLE_RATE / 2000. With the default rate of 48000, code 000 gives 24 samples and code 111 gives 192 samples.
- R6: Until at least D samples have been accepted since reset, d is zero, which makes `left` equal `right`.
- R7: `delay_code` is sampled only at clock edges where `rst_n` is low. A change of `delay_code` after reset has no effect on D.
- R8: Only cycles with `in_valid` high write the delay line and advance it. Idle cycles between samples do not change which earlier sample is paired with the next one.
- R9: The pairing stays correct after the write position wraps past the end of the buffer, including at the longest setting, where D equals the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the delay code is taken |
| in_valid | input | 1 | A mono sample is offered this cycle |
| in_sample | input | DATA_W | Signed mono sample |
| delay_code | input | 3 | Delay setting, D = (code + 1) half-milliseconds |
| out_valid | output | 1 | One-cycle strobe marking a new output pair |
| left | output | DATA_W | Signed left sample, (x − d) / 2 |
| right | output | DATA_W | Signed right sample, (x + d) / 2 |

## Verification
The hardest case to reach is the wrap of the circular buffer at the longest setting. There the read slot and the write slot are the same, and the value read must be the old content before it is overwritten. To reach it, the stimulus resets with code 111 and streams more than twice the buffer depth of distinct ramp values back to back, so every read slot is checked after at least one wrap. Idle gaps of varying length are mixed into a separate run to show that the delay counts samples, not cycles. A further run changes the code after reset and confirms that the first setting is kept.

// File: rtl/comb_pkg.sv
// Package comb_pkg
// Holds the arithmetic shared by the stereo synthesizer modules: how
// many samples one half-millisecond step spans at a given sample rate.
// Assumes the sample rate is a whole multiple of 2000 Hz.
package comb_pkg;

    // Number of samples per half-millisecond delay step.
    function automatic int calc_step(input int rate_hz);
        return rate_hz / 2000;
    endfunction

    // Buffer depth needed to hold the longest of the n_set settings.
    function automatic int calc_depth(input int rate_hz, input int n_set);
        return calc_step(rate_hz) * n_set;
    endfunction

endpackage

// File: rtl/comb_delay_cfg.sv
// Module comb_delay_cfg
// Turns the delay code into a delay length in samples and holds it.
// The code is taken only while reset is asserted, so the setting stays
// fixed from the end of reset until the next reset.
// Assumes CW is wide enough to hold N_SET * STEP.
module comb_delay_cfg #(
    parameter int CODE_W = 3,
    parameter int STEP   = 24,
    parameter int CW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [CW-1:0]     dly_len
);
    localparam int N_SET = 1 << CODE_W;

    logic [CW-1:0] len_tbl [N_SET];

    // One table entry for each setting: (index + 1) steps.
    for (genvar g = 0; g < N_SET; g++) begin : g_len
        assign len_tbl[g] = CW'((g + 1) * STEP);
    end

    // Capture the selected length while reset is held; hold it after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_len <= len_tbl[code];
        end
    end

endmodule

// File: rtl/comb_line.sv
// Module comb_line
// Circular delay buffer with one write pointer. Each accepted sample is
// written at the pointer. The tap reads the slot dly_len places behind
// the pointer, modulo DEPTH, through an asynchronous read, so the tap
// sees the old content even when the read and write slots coincide.
// Until dly_len samples have been written since reset, the tap is zero.
// Assumes 1 <= dly_len <= DEPTH and that dly_len is stable after reset.
module comb_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 192,
    parameter int AW     = 8,
    parameter int CW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW-1:0]     dly_len,
    output logic [DATA_W-1:0] tap,
    output logic [CW-1:0]     fill_cnt
);
    localparam logic [CW-1:0] LAST  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     wr_ptr;
    logic [CW-1:0]     back_off;
    logic [CW-1:0]     rd_ptr;
    logic              primed;

    // Advance the write pointer on each accepted sample, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Count accepted samples since reset, saturating at the buffer depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (wr_en && (fill_cnt != FULL)) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Store the accepted sample; the memory itself needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    // Read address: pointer minus delay, folded back into [0, DEPTH).
    always_comb begin
        back_off = FULL - dly_len;
        if (wr_ptr >= dly_len) begin
            rd_ptr = wr_ptr - dly_len;
        end else begin
            rd_ptr = wr_ptr + back_off;
        end
    end

    // Tap is valid only once the selected span has been written.
    always_comb begin
        primed = (fill_cnt >= dly_len);
        tap    = primed ? mem[rd_ptr[AW-1:0]] : '0;
    end

endmodule

// File: rtl/comb_mix.sv
// Module comb_mix
// Forms the sum and difference of the current sample and its delayed
// partner at one extra bit, halves both by an arithmetic shift and
// registers them. The valid strobe follows the accepted sample by one
// clock. Assumes both inputs are two's complement.
module comb_mix #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] dly,
    output logic              out_valid,
    output logic [DATA_W-1:0] left,
    output logic [DATA_W-1:0] right
);
    logic [DATA_W:0] cur_x;
    logic [DATA_W:0] dly_x;
    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;

    // Sign-extend by one bit so neither result can wrap.
    always_comb begin
        cur_x = {cur[DATA_W-1], cur};
        dly_x = {dly[DATA_W-1], dly};
        sum_w = cur_x + dly_x;
        dif_w = cur_x - dly_x;
    end

    // Register halved results; hold them when no sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            right <= '0;
            left  <= '0;
        end else if (in_valid) begin
            right <= sum_w[DATA_W:1];
            left  <= dif_w[DATA_W:1];
        end
    end

    // One-cycle strobe for each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/comb_stereo.sv
// Module comb_stereo
// Top of the comb-filter stereo synthesizer. A mono sample goes into a
// circular delay buffer, and is mixed with the sample D accepted samples
// older: the sum drives the right channel and the difference drives the
// left. D is fixed at reset from delay_code.
// Assumes SAMPLE_RATE is a multiple of 2000 Hz and the resulting depth
// stays within a few thousand entries.
module comb_stereo #(
    parameter int DATA_W      = 16,
    parameter int SAMPLE_RATE = 48000,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [CODE_W-1:0] delay_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] left,
    output logic [DATA_W-1:0] right
);
    import comb_pkg::*;

    localparam int STEP  = calc_step(SAMPLE_RATE);
    localparam int N_SET = 1 << CODE_W;
    localparam int DEPTH = calc_depth(SAMPLE_RATE, N_SET);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [CW-1:0]     dly_len;
    logic [CW-1:0]     fill_cnt;
    logic [DATA_W-1:0] tap;

    comb_delay_cfg #(
        .CODE_W (CODE_W),
        .STEP   (STEP),
        .CW     (CW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (delay_code),
        .dly_len (dly_len)
    );

    comb_line #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW),
        .CW     (CW)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid),
        .wr_data  (in_sample),
        .dly_len  (dly_len),
        .tap      (tap),
        .fill_cnt (fill_cnt)
    );

    comb_mix #(
        .DATA_W (DATA_W)
    ) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cur       (in_sample),
        .dly       (tap),
        .out_valid (out_valid),
        .left      (left),
        .right     (right)
    );

endmodule

// File: rtl/comb_stereo_chk.sv
// Module comb_stereo_chk
// Property checker bound to comb_stereo. It watches the ports together
// with the held delay length and the fill count.
module comb_stereo_chk #(
    parameter int DATA_W = 16,
    parameter int CW     = 8,
    parameter int DEPTH  = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              out_valid,
    input logic [DATA_W-1:0] left,
    input logic [DATA_W-1:0] right,
    input logic [CW-1:0]     dly_len,
    input logic [CW-1:0]     fill_cnt
);
    logic [DATA_W:0] lr_sum;
    logic [DATA_W:0] in_ext;

    // Sum of the two channels and the widened input, for the R3/R4 check.
    always_comb begin
        lr_sum = {left[DATA_W-1], left} + {right[DATA_W-1], right};
        in_ext = {in_sample[DATA_W-1], in_sample};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && left == '0 && right == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(left) && $stable(right)));

    // R3 and R4 together: the halves add back to the input, less at most one.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lr_sum == $past(in_ext) || lr_sum == $past(in_ext) - 1'b1));

    p_zero_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(fill_cnt) < $past(dly_len))) |-> (left == right));

    p_len_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dly_len));

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

endmodule

bind comb_stereo comb_stereo_chk #(
    .DATA_W (DATA_W),
    .CW     (CW),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .left      (left),
    .right     (right),
    .dly_len   (dly_len),
    .fill_cnt  (fill_cnt)
);

// File: tb/sim_comb_stereo.sv
`timescale 1ns/1ps
// Directed bench for comb_stereo. A reference history of accepted
// samples gives the expected delayed partner of each sample.
module sim_comb_stereo;
    localparam int DW   = 16;
    localparam int STEP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic [2:0]    delay_code = 3'd0;
    logic          out_valid;
    logic [DW-1:0] left;
    logic [DW-1:0] right;

    int n_chk = 0;
    int n_err = 0;
    int hist [0:1023];
    int n_acc = 0;
    int dlen  = STEP;
    int prev_l = 0;
    int prev_r = 0;

    comb_stereo #(.DATA_W(DW), .SAMPLE_RATE(48000), .CODE_W(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .delay_code (delay_code),
        .out_valid  (out_valid),
        .left       (left),
        .right      (right)
    );

    always #2.5 clk = ~clk;

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reset with a given code; R1 checked while reset is held.
    task automatic do_reset(input int code);
        rst_n = 1'b0;
        in_valid = 1'b0;
        delay_code = 3'(code);
        repeat (3) @(negedge clk);
        check_eq("R1", "out_valid in reset", int'(out_valid), 0);
        check_eq("R1", "left in reset", int'($signed(left)), 0);
        check_eq("R1", "right in reset", int'($signed(right)), 0);
        rst_n = 1'b1;
        n_acc = 0;
        dlen = (code + 1) * STEP;
        prev_l = 0;
        prev_r = 0;
    endtask

    // One cycle: offer a sample (or idle) and check the result next cycle.
    task automatic step(input bit v, input int x, input string tag);
        int d;
        int er;
        int el;
        in_valid = v;
        in_sample = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        if (v) begin
            d = (n_acc >= dlen) ? hist[n_acc - dlen] : 0;
            hist[n_acc] = x;
            n_acc++;
            er = (x + d) >>> 1;
            el = (x - d) >>> 1;
            check_eq({tag, "/R2"}, "out_valid", int'(out_valid), 1);
            check_eq({tag, "/R3"}, "right", int'($signed(right)), er);
            check_eq({tag, "/R4"}, "left", int'($signed(left)), el);
        end else begin
            check_eq({tag, "/R2"}, "out_valid idle", int'(out_valid), 0);
            check_eq({tag, "/R2"}, "left held", int'($signed(left)), prev_l);
            check_eq({tag, "/R2"}, "right held", int'($signed(right)), prev_r);
        end
        prev_l = int'($signed(left));
        prev_r = int'($signed(right));
    endtask

    // R5/R6: impulse at the shortest setting, echo after 24 samples.
    task automatic t_impulse();
        do_reset(0);
        step(1'b1, 1000, "R6");
        for (int i = 1; i < 40; i++) step(1'b1, 0, "R5");
        step(1'b1, 5, "R5");
    endtask

    // R9: long ramp at the longest setting, wrapping the buffer twice.
    task automatic t_wrap();
        do_reset(7);
        for (int i = 0; i < 450; i++) step(1'b1, ((i * 7919) % 65536) - 32768, "R9");
    endtask

    // R8: idle gaps of varying length between samples.
    task automatic t_gaps();
        do_reset(1);
        for (int i = 0; i < 110; i++) begin
            step(1'b1, (i * 311) - 17000, "R8");
            for (int k = 0; k < (i % 4); k++) step(1'b0, 0, "R8");
        end
    endtask

    // R7: change the code after reset; the reset-time setting must stay.
    task automatic t_code_change();
        do_reset(2);
        delay_code = 3'd5;
        for (int i = 0; i < 160; i++) step(1'b1, (i % 13) * 900 - 5000, "R7");
    endtask

    // R3/R4: full-scale values at both extremes must not wrap.
    task automatic t_extremes();
        do_reset(0);
        for (int i = 0; i < 80; i++) step(1'b1, (i % 2 == 0) ? 32767 : -32768, "R3");
        for (int i = 0; i < 30; i++) step(1'b1, -32768, "R4");
    endtask

    initial begin
        @(negedge clk);
        t_impulse();
        t_wrap();
        t_gaps();
        t_code_change();
        t_extremes();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule